// File: doc/BRIEF.md
# MDIO Management Slave (Indirect Register Access)

This block is the serial end of a management port. It runs on the management clock (MDC), listens to a shared open-drain data line, and turns indirect-access frames into accesses on a plain parallel register bus. A frame is answered only when its port field equals the 5-bit strap input and its device field names one of the supported devices. Each supported device has its own 16-bit stored register address. An address frame sets the stored address, and later data frames use it. A read with post-increment advances the stored address once its data has gone out.

The line is sampled on the rising edge of MDC. The slave's drive enable and drive value are retimed onto the falling edge, so the master always sees settled data at its next rising edge. The register file, the pad and the pull-up sit outside the block. The bench models them with a combinational read function and a wired-AND line.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the drive enable is low, neither strobe is active, and every stored address is 0x0000.
- R2: A frame is accepted only after at least 32 consecutive ones followed by the start bits 00. The fields that follow are opcode (2 bits), port (5), device (5), turnaround (2) and address/data (16), each sent MSB first. With 31 ones or fewer the frame is ignored and counting starts again. A run longer than 32 is accepted.
- R3: A frame whose port field differs from `port_strap` causes no strobe, no line drive and no change to any stored address.
- R4: Only device numbers 1, 3 and 4 are answered. Frames to any other device cause no strobe, no line drive and no change to any stored address.
- R5: An address frame (opcode 00) loads its 16-bit field into the stored address of its own device only. It raises no strobe and never drives the line.
- R6: A write frame (opcode 01) gives a single-cycle `reg_wr_en` in the cycle after the last data bit is sampled. `reg_wdata` holds the 16 received bits with the first bit received at bit 15, and `reg_addr` holds the device's stored address.
- R7: A read (opcode 11) or read-with-increment (opcode 10) gives a single-cycle `reg_rd_en` in the cycle after the last device bit is sampled. `reg_rdata` is taken at the end of that cycle and is sent on the line bit 15 first, one bit per MDC period, right after turnaround.
- R8: In a read, the slave leaves the line released for the first turnaround bit and drives 0 for the second.
- R9: A read-with-increment adds one to the device's stored address after the data field, wrapping from 0xFFFF to 0x0000. A plain read leaves the stored address unchanged.
- R10: In a read, the line is driven for exactly 17 bit periods (turnaround zero plus 16 data bits) and is released before the bit period that follows data bit 0.
- R11: The drive enable and drive value change only on the falling edge of MDC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; rising edge samples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_strap | input | 5 | Port number this slave answers to |
| mdio_in | input | 1 | Sampled state of the shared data line |
| mdio_oe | output | 1 | Pull-down driver enable |
| mdio_out | output | 1 | Value to drive while enabled (0 pulls low) |
| reg_dev | output | 5 | Device number of the frame being served |
| reg_addr | output | 16 | Stored register address of that device |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 16 | Write data from the frame |
| reg_rd_en | output | 1 | Single-cycle read request |
| reg_rdata | input | 16 | Read data, valid while `reg_rd_en` is high |

## Verification
The bound checker watches every rising edge of MDC. It checks that each strobe lasts one cycle and that the two strobes never coincide. It checks that a strobe only names a supported device, that a read request is followed by a released line and then a driven zero, and that the drive window never exceeds 17 bit periods. The directed scenarios cover the rest. These are the preamble count threshold, port and device filtering, the per-device address storage with increment and wrap, the bit order of write and read data, and the falling-edge timing of the driver. Their results show up only as a sequence over whole frames or through later reads.

// File: rtl/mdio_slv_pkg.sv
`timescale 1ns/1ps
package mdio_slv_pkg;

    // Frame progress, one value per field group
    typedef enum logic [2:0] {
        PH_HUNT,   // counting preamble ones
        PH_START,  // first start zero seen, waiting for the second
        PH_HDR,    // opcode, port and device bits
        PH_TA1,    // first turnaround bit
        PH_TA2,    // second turnaround bit
        PH_DATA    // 16-bit address/data field
    } phase_e;

    // Opcode values carried on the line
    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RDINC = 2'b10,
        OP_READ  = 2'b11
    } opcode_e;

    function automatic logic op_is_read(input opcode_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/mdio_frame_ctl.sv
`timescale 1ns/1ps
module mdio_frame_ctl
    import mdio_slv_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PA_W    = 5,
    parameter int DA_W    = 5,
    parameter int DW      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mdio_in,
    input  logic [PA_W-1:0] port_strap,
    input  logic            dev_hit,
    input  logic [DW-1:0]   rdata,
    output logic [DA_W-1:0] hdr_dev,
    output logic [DA_W-1:0] cur_dev,
    output logic            wr_en,
    output logic            rd_en,
    output logic            ld_addr,
    output logic            inc_addr,
    output logic [DW-1:0]   rx_word,
    output logic            drv_en,
    output logic            drv_bit
);

    localparam int HDR_W  = 2 + PA_W + DA_W;
    localparam int PRE_CW = $clog2(PRE_LEN + 1);
    localparam int MAXF   = (DW > HDR_W) ? DW : HDR_W;
    localparam int CNT_W  = $clog2(MAXF);
    localparam logic [PRE_CW-1:0] PRE_FULL  = PRE_CW'(PRE_LEN);
    localparam logic [CNT_W-1:0]  HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DW - 1);

    typedef struct packed {
        phase_e             phase;
        logic [PRE_CW-1:0]  pre_cnt;
        logic [CNT_W-1:0]   bit_cnt;
        logic [HDR_W-1:0]   hdr;
        opcode_e            op;
        logic [DA_W-1:0]    dev;
        logic [DW-1:0]      rx;
        logic [DW-1:0]      tx;
        logic               wr_en;
        logic               rd_en;
        logic               ld;
        logic               inc;
    } ctl_t;

    ctl_t q, d;

    // Header as it stands once the current bit is shifted in
    logic [HDR_W-1:0] hdr_next;
    opcode_e          op_f;
    logic [PA_W-1:0]  port_f;

    assign hdr_next = {q.hdr[HDR_W-2:0], mdio_in};
    assign op_f     = opcode_e'(hdr_next[HDR_W-1 -: 2]);
    assign port_f   = hdr_next[DA_W +: PA_W];
    assign hdr_dev  = hdr_next[DA_W-1:0];

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.rd_en = 1'b0;
        d.ld    = 1'b0;
        d.inc   = 1'b0;
        unique case (q.phase)
            PH_HUNT: begin
                // R2: saturating count of consecutive ones
                if (mdio_in) begin
                    if (q.pre_cnt != PRE_FULL) begin
                        d.pre_cnt = q.pre_cnt + 1'b1;
                    end
                end else begin
                    if (q.pre_cnt == PRE_FULL) begin
                        d.phase = PH_START;
                    end
                    d.pre_cnt = '0;
                end
            end
            PH_START: begin
                if (!mdio_in) begin
                    d.phase   = PH_HDR;
                    d.bit_cnt = HDR_LAST;
                end else begin
                    d.phase   = PH_HUNT;
                    d.pre_cnt = PRE_CW'(1);
                end
            end
            PH_HDR: begin
                d.hdr = hdr_next;
                if (q.bit_cnt == '0) begin
                    // R3, R4: both filters must pass
                    if (port_f == port_strap && dev_hit) begin
                        d.phase = PH_TA1;
                        d.op    = op_f;
                        d.dev   = hdr_dev;
                        d.rd_en = op_is_read(op_f);   // R7
                    end else begin
                        d.phase   = PH_HUNT;
                        d.pre_cnt = '0;
                    end
                end else begin
                    d.bit_cnt = q.bit_cnt - 1'b1;
                end
            end
            PH_TA1: begin
                d.phase = PH_TA2;
                if (op_is_read(q.op)) begin
                    d.tx = rdata;
                end
            end
            PH_TA2: begin
                d.phase   = PH_DATA;
                d.bit_cnt = DATA_LAST;
            end
            PH_DATA: begin
                d.rx = {q.rx[DW-2:0], mdio_in};
                d.tx = {q.tx[DW-2:0], 1'b0};
                if (q.bit_cnt == '0) begin
                    d.phase   = PH_HUNT;
                    d.pre_cnt = '0;
                    unique case (q.op)
                        OP_ADDR:  d.ld    = 1'b1;  // R5
                        OP_WRITE: d.wr_en = 1'b1;  // R6
                        OP_RDINC: d.inc   = 1'b1;  // R9
                        default:  ;
                    endcase
                end else begin
                    d.bit_cnt = q.bit_cnt - 1'b1;
                end
            end
            default: begin
                d.phase   = PH_HUNT;
                d.pre_cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_dev  = q.dev;
    assign wr_en    = q.wr_en;
    assign rd_en    = q.rd_en;
    assign ld_addr  = q.ld;
    assign inc_addr = q.inc;
    assign rx_word  = q.rx;

    // R8, R10: drive window covers second turnaround bit and the data field
    assign drv_en  = op_is_read(q.op) && (q.phase == PH_TA2 || q.phase == PH_DATA);
    assign drv_bit = (q.phase == PH_DATA) ? q.tx[DW-1] : 1'b0;

endmodule

// File: rtl/mdio_addr_bank.sv
`timescale 1ns/1ps
module mdio_addr_bank #(
    parameter int                      DA_W     = 5,
    parameter int                      DW       = 16,
    parameter int                      NUM_DEV  = 3,
    parameter logic [NUM_DEV*DA_W-1:0] DEV_LIST = {5'd4, 5'd3, 5'd1}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DA_W-1:0] hdr_dev,
    input  logic [DA_W-1:0] cur_dev,
    input  logic            ld,
    input  logic            inc,
    input  logic [DW-1:0]   ld_val,
    output logic            dev_hit,
    output logic [DW-1:0]   cur_addr
);

    logic [NUM_DEV-1:0] hit_vec;
    logic [NUM_DEV-1:0] sel_vec;
    logic [DW-1:0]      addr_w [NUM_DEV];

    for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_dev
        localparam logic [DA_W-1:0] DEV_ID = DEV_LIST[gi*DA_W +: DA_W];

        logic [DW-1:0] addr_d, addr_q;

        assign hit_vec[gi] = (hdr_dev == DEV_ID);
        assign sel_vec[gi] = (cur_dev == DEV_ID);

        // R5, R9: only the selected device's entry moves
        always_comb begin
            addr_d = addr_q;
            if (sel_vec[gi]) begin
                if (ld) begin
                    addr_d = ld_val;
                end else if (inc) begin
                    addr_d = addr_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= '0;
            end else begin
                addr_q <= addr_d;
            end
        end

        assign addr_w[gi] = addr_q;
    end

    assign dev_hit = |hit_vec;

    always_comb begin
        cur_addr = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel_vec[i]) begin
                cur_addr = cur_addr | addr_w[i];
            end
        end
    end

endmodule

// File: rtl/mdio_line_drv.sv
`timescale 1ns/1ps
module mdio_line_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic drv_bit,
    output logic mdio_oe,
    output logic mdio_out
);

    typedef struct packed {
        logic oe;
        logic val;
    } drv_t;

    drv_t q, d;

    always_comb begin
        d.oe  = drv_en;
        d.val = drv_en ? drv_bit : 1'b1;
    end

    // R11: retimed onto the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{oe: 1'b0, val: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign mdio_oe  = q.oe;
    assign mdio_out = q.val;

endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave #(
    parameter int                      PRE_LEN  = 32,
    parameter int                      PA_W     = 5,
    parameter int                      DA_W     = 5,
    parameter int                      DW       = 16,
    parameter int                      NUM_DEV  = 3,
    parameter logic [NUM_DEV*DA_W-1:0] DEV_LIST = {5'd4, 5'd3, 5'd1}
) (
    input  logic            mdc,
    input  logic            rst_n,
    input  logic [PA_W-1:0] port_strap,
    input  logic            mdio_in,
    output logic            mdio_oe,
    output logic            mdio_out,
    output logic [DA_W-1:0] reg_dev,
    output logic [DW-1:0]   reg_addr,
    output logic            reg_wr_en,
    output logic [DW-1:0]   reg_wdata,
    output logic            reg_rd_en,
    input  logic [DW-1:0]   reg_rdata
);

    logic [DA_W-1:0] hdr_dev;
    logic [DA_W-1:0] cur_dev;
    logic            dev_hit;
    logic            ld_addr;
    logic            inc_addr;
    logic [DW-1:0]   rx_word;
    logic            drv_en;
    logic            drv_bit;

    mdio_frame_ctl #(
        .PRE_LEN (PRE_LEN),
        .PA_W    (PA_W),
        .DA_W    (DA_W),
        .DW      (DW)
    ) u_ctl (
        .clk        (mdc),
        .rst_n      (rst_n),
        .mdio_in    (mdio_in),
        .port_strap (port_strap),
        .dev_hit    (dev_hit),
        .rdata      (reg_rdata),
        .hdr_dev    (hdr_dev),
        .cur_dev    (cur_dev),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .ld_addr    (ld_addr),
        .inc_addr   (inc_addr),
        .rx_word    (rx_word),
        .drv_en     (drv_en),
        .drv_bit    (drv_bit)
    );

    mdio_addr_bank #(
        .DA_W     (DA_W),
        .DW       (DW),
        .NUM_DEV  (NUM_DEV),
        .DEV_LIST (DEV_LIST)
    ) u_bank (
        .clk      (mdc),
        .rst_n    (rst_n),
        .hdr_dev  (hdr_dev),
        .cur_dev  (cur_dev),
        .ld       (ld_addr),
        .inc      (inc_addr),
        .ld_val   (rx_word),
        .dev_hit  (dev_hit),
        .cur_addr (reg_addr)
    );

    mdio_line_drv u_drv (
        .clk      (mdc),
        .rst_n    (rst_n),
        .drv_en   (drv_en),
        .drv_bit  (drv_bit),
        .mdio_oe  (mdio_oe),
        .mdio_out (mdio_out)
    );

    assign reg_dev   = cur_dev;
    assign reg_wdata = rx_word;

endmodule

// File: rtl/mdio_slave_chk.sv
`timescale 1ns/1ps
module mdio_slave_chk #(
    parameter int                      DA_W     = 5,
    parameter int                      DW       = 16,
    parameter int                      NUM_DEV  = 3,
    parameter logic [NUM_DEV*DA_W-1:0] DEV_LIST = {5'd4, 5'd3, 5'd1}
) (
    input logic            mdc,
    input logic            rst_n,
    input logic            mdio_oe,
    input logic            mdio_out,
    input logic            reg_wr_en,
    input logic            reg_rd_en,
    input logic [DA_W-1:0] reg_dev
);

    localparam int OE_MAX = DW + 1;
    localparam int RUN_W  = $clog2(OE_MAX + 2);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(OE_MAX + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(OE_MAX);

    logic [RUN_W-1:0] oe_run;
    logic             dev_known;

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            oe_run <= '0;
        end else if (mdio_oe) begin
            oe_run <= (oe_run == RUN_SAT) ? oe_run : oe_run + 1'b1;
        end else begin
            oe_run <= '0;
        end
    end

    always_comb begin
        dev_known = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (reg_dev == DEV_LIST[i*DA_W +: DA_W]) begin
                dev_known = 1'b1;
            end
        end
    end

    assert_wr_single_R6: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    assert_rd_single_R7: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    assert_strobe_excl_R6: assert property (@(posedge mdc) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    assert_dev_filter_R4: assert property (@(posedge mdc) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> dev_known);

    assert_ta_release_R8: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd_en |-> !mdio_oe);

    assert_ta_zero_R8: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd_en |=> (mdio_oe && !mdio_out));

    assert_oe_window_R10: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run <= RUN_LIM);

endmodule

bind mdio_mgmt_slave mdio_slave_chk #(
    .DA_W     (DA_W),
    .DW       (DW),
    .NUM_DEV  (NUM_DEV),
    .DEV_LIST (DEV_LIST)
) u_chk (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_dev   (reg_dev)
);

// File: tb/tb_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_slave;

    localparam logic [4:0] STRAP = 5'h0B;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mbit = 1'b1;
    logic [4:0]  port_strap = STRAP;
    logic        mdio_in;
    logic        mdio_oe, mdio_out;
    logic [4:0]  reg_dev;
    logic [15:0] reg_addr, reg_wdata, reg_rdata;
    logic        reg_wr_en, reg_rd_en;

    int checks = 0;
    int fails  = 0;

    // frame observations
    int          n_rd, n_wr, n_oe, edge_bad;
    logic [15:0] rd_addr, wr_addr, wr_data, rd_bits;
    logic [4:0]  rd_dev;
    logic        ta1_oe, ta2_oe, ta2_out, post_oe;

    always #5 mdc = ~mdc;

    // wired-AND line: released master reads as one
    assign mdio_in = mbit & ~(mdio_oe & ~mdio_out);

    function automatic logic [15:0] model(input logic [4:0] dev, input logic [15:0] a);
        return a ^ 16'h5A3C ^ {dev, 11'd0};
    endfunction

    assign reg_rdata = model(reg_dev, reg_addr);

    mdio_mgmt_slave dut (
        .mdc        (mdc),
        .rst_n      (rst_n),
        .port_strap (port_strap),
        .mdio_in    (mdio_in),
        .mdio_oe    (mdio_oe),
        .mdio_out   (mdio_out),
        .reg_dev    (reg_dev),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rd_en  (reg_rd_en),
        .reg_rdata  (reg_rdata)
    );

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one bit period: drive after the falling edge, look just before and after the rising edge
    task automatic send_slot(input logic b, input int idx);
        logic oe_a, out_a;
        @(negedge mdc);
        mbit = b;
        #4;
        if (reg_rd_en) begin n_rd++; rd_addr = reg_addr; rd_dev = reg_dev; end
        if (reg_wr_en) begin n_wr++; wr_addr = reg_addr; wr_data = reg_wdata; end
        if (mdio_oe) n_oe++;
        if (idx == 14) ta1_oe = mdio_oe;
        if (idx == 15) begin ta2_oe = mdio_oe; ta2_out = mdio_out; end
        if (idx >= 16 && idx <= 31) rd_bits[31-idx] = mdio_in;
        if (idx == 32) post_oe = mdio_oe;
        oe_a  = mdio_oe;
        out_a = mdio_out;
        #2;
        if (mdio_oe !== oe_a || mdio_out !== out_a) edge_bad++;
    endtask

    task automatic run_frame(input int pre_len, input logic [1:0] op, input logic [4:0] prt,
                             input logic [4:0] dev, input logic [15:0] data);
        n_rd = 0; n_wr = 0; n_oe = 0; edge_bad = 0;
        rd_addr = 'x; wr_addr = 'x; wr_data = 'x; rd_bits = 'x; rd_dev = 'x;
        ta1_oe = 1'bx; ta2_oe = 1'bx; ta2_out = 1'bx; post_oe = 1'bx;
        send_slot(1'b0, -1);
        for (int i = 0; i < pre_len; i++) send_slot(1'b1, -1);
        send_slot(1'b0, 0);
        send_slot(1'b0, 1);
        for (int i = 0; i < 2; i++) send_slot(op[1-i], 2 + i);
        for (int i = 0; i < 5; i++) send_slot(prt[4-i], 4 + i);
        for (int i = 0; i < 5; i++) send_slot(dev[4-i], 9 + i);
        if (op[1]) begin
            send_slot(1'b1, 14);
            send_slot(1'b1, 15);
            for (int i = 0; i < 16; i++) send_slot(1'b1, 16 + i);
        end else begin
            send_slot(1'b1, 14);
            send_slot(1'b0, 15);
            for (int i = 0; i < 16; i++) send_slot(data[15-i], 16 + i);
        end
        send_slot(1'b1, 32);
        send_slot(1'b1, 33);
    endtask

    task automatic do_read(input logic [4:0] dev, input logic inc,
                           input logic [15:0] exp_addr, input string tag);
        run_frame(32, inc ? 2'b10 : 2'b11, STRAP, dev, 16'h0);
        chk_eq("R7", "read strobe count", n_rd, 1);
        chk_eq(tag, "read address", rd_addr, exp_addr);
        chk_eq("R7", "read data on line", rd_bits, model(dev, exp_addr));
        chk_eq("R8", "first turnaround released", ta1_oe, 1'b0);
        chk_eq("R8", "second turnaround driven zero", {ta2_oe, ta2_out}, 2'b10);
        chk_eq("R10", "drive length", n_oe, 17);
        chk_eq("R10", "released after last bit", post_oe, 1'b0);
        chk_eq("R11", "output moved at rising edge", edge_bad, 0);
        chk_eq("R6", "no write during read", n_wr, 0);
    endtask

    task automatic expect_silent(input string tag);
        chk_eq(tag, "no read strobe", n_rd, 0);
        chk_eq(tag, "no write strobe", n_wr, 0);
        chk_eq(tag, "line never driven", n_oe, 0);
    endtask

    task automatic t_reset();
        #1;
        chk_eq("R1", "oe in reset", mdio_oe, 1'b0);
        chk_eq("R1", "strobes in reset", {reg_wr_en, reg_rd_en}, 2'b00);
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        #4;
        chk_eq("R1", "oe after reset", mdio_oe, 1'b0);
        chk_eq("R1", "strobes after reset", {reg_wr_en, reg_rd_en}, 2'b00);
        do_read(5'd3, 1'b0, 16'h0000, "R1");
        do_read(5'd4, 1'b0, 16'h0000, "R1");
    endtask

    task automatic t_addr_read();
        run_frame(32, 2'b00, STRAP, 5'd1, 16'h1234);
        expect_silent("R5");
        do_read(5'd1, 1'b0, 16'h1234, "R5");
    endtask

    task automatic t_write();
        run_frame(32, 2'b01, STRAP, 5'd1, 16'hBEEF);
        chk_eq("R6", "write strobe count", n_wr, 1);
        chk_eq("R6", "write address", wr_addr, 16'h1234);
        chk_eq("R6", "write data", wr_data, 16'hBEEF);
        chk_eq("R6", "line not driven on write", n_oe, 0);
        run_frame(32, 2'b01, STRAP, 5'd1, 16'h8001);
        chk_eq("R6", "write data msb first", wr_data, 16'h8001);
        do_read(5'd1, 1'b0, 16'h1234, "R6");
    endtask

    task automatic t_read_inc();
        do_read(5'd1, 1'b1, 16'h1234, "R9");
        do_read(5'd1, 1'b1, 16'h1235, "R9");
        do_read(5'd1, 1'b0, 16'h1236, "R9");
        do_read(5'd1, 1'b0, 16'h1236, "R9");
    endtask

    task automatic t_per_dev();
        run_frame(32, 2'b00, STRAP, 5'd3, 16'h00FF);
        expect_silent("R5");
        run_frame(32, 2'b00, STRAP, 5'd4, 16'hFFFF);
        do_read(5'd4, 1'b1, 16'hFFFF, "R9");
        do_read(5'd4, 1'b0, 16'h0000, "R9");
        do_read(5'd3, 1'b0, 16'h00FF, "R5");
        do_read(5'd1, 1'b0, 16'h1236, "R5");
    endtask

    task automatic t_port_mismatch();
        run_frame(32, 2'b00, 5'h0C, 5'd1, 16'h5555);
        expect_silent("R3");
        run_frame(32, 2'b11, 5'h0A, 5'd1, 16'h0);
        expect_silent("R3");
        run_frame(32, 2'b01, 5'h1B, 5'd3, 16'h1111);
        expect_silent("R3");
        do_read(5'd1, 1'b0, 16'h1236, "R3");
        do_read(5'd3, 1'b0, 16'h00FF, "R3");
    endtask

    task automatic t_dev_filter();
        run_frame(32, 2'b00, STRAP, 5'd2, 16'h7777);
        expect_silent("R4");
        run_frame(32, 2'b01, STRAP, 5'd2, 16'h7777);
        expect_silent("R4");
        run_frame(32, 2'b11, STRAP, 5'd0, 16'h0);
        expect_silent("R4");
        run_frame(32, 2'b10, STRAP, 5'd31, 16'h0);
        expect_silent("R4");
        do_read(5'd1, 1'b0, 16'h1236, "R4");
    endtask

    task automatic t_preamble();
        run_frame(31, 2'b01, STRAP, 5'd1, 16'hCAFE);
        expect_silent("R2");
        run_frame(31, 2'b00, STRAP, 5'd3, 16'h4444);
        expect_silent("R2");
        do_read(5'd3, 1'b0, 16'h00FF, "R2");
        run_frame(32, 2'b01, STRAP, 5'd1, 16'hCAFE);
        chk_eq("R2", "exact preamble write", n_wr, 1);
        chk_eq("R2", "exact preamble data", wr_data, 16'hCAFE);
        run_frame(40, 2'b00, STRAP, 5'd3, 16'h0A0A);
        chk_eq("R2", "long preamble no strobe", n_wr + n_rd, 0);
        do_read(5'd3, 1'b0, 16'h0A0A, "R2");
    endtask

    initial begin
        t_reset();
        t_addr_read();
        t_write();
        t_read_inc();
        t_per_dev();
        t_port_mismatch();
        t_dev_filter();
        t_preamble();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mdc);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule